// File: doc/BRIEF.md
# Add-With-Carry Arithmetic Unit

This block adds a destination operand, a source operand and an incoming carry bit. The operand width is 8, 16, 32 or 64 bits, selected per operation. It returns the value to write back to the full 64-bit destination register, together with six status flags: carry, overflow, sign, zero, nibble carry and parity. The caller must sign-extend any short immediate into the 64-bit source before it presents the source.

A one-cycle pulse on `start` captures the operands. On the next clock edge the registered result and flags update and `valid` goes high for exactly one cycle. The control is a two-state machine. `ST_IDLE` waits for `start`. The transition `T_LAUNCH` (start seen) moves to `ST_EMIT`, where `valid` is asserted. From `ST_EMIT`, `T_CHAIN` (a new start) stays in `ST_EMIT`, and `T_RETIRE` (no start) returns to `ST_IDLE`. Wide additions are chained by feeding one operation's carry flag into the next operation's carry input.

Top module: `adc_alu`

## Requirements
- R1: The low bits of `wb_value` at the selected width equal (dest_old + src + carry_in) truncated to that width. The width codes are `size` 0 = 8, 1 = 16, 2 = 32 and 3 = 64 bits.
- R2: `flag_cf` is the carry out of the top bit of the selected width, with the incoming carry counted in the sum.
- R3: `flag_of` is set when both operands have the same sign bit at the selected width and the result sign bit differs from it.
- R4: `flag_sf` equals the most significant bit of the result at the selected width.
- R5: `flag_zf` is set exactly when the truncated result is zero.
- R6: `flag_af` is the carry out of bit 3 of the sum, with the incoming carry included.
- R7: `flag_pf` is set when result bits 7:0 hold an even number of ones, whatever the width.
- R8: For 8-bit and 16-bit operations, the bits of `wb_value` above the operand width equal the old destination bits.
- R9: For 32-bit operations, bits 63:32 of `wb_value` are zero.
- R10: For 64-bit operations, all 64 bits of `wb_value` are the sum.
- R11: `valid` is high in the cycle after each `start` and low in every other cycle. Result and flags change only in cycles after a `start`.
- R12: After reset, `valid`, `wb_value` and all flags are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Capture operands and compute |
| size | input | 2 | Operand width code (0:8, 1:16, 2:32, 3:64) |
| dest_old | input | 64 | Current full destination register value |
| src | input | 64 | Source operand, already sign-extended |
| carry_in | input | 1 | Incoming carry |
| wb_value | output | 64 | Merged value for the destination register |
| flag_cf | output | 1 | Carry out |
| flag_of | output | 1 | Signed overflow |
| flag_sf | output | 1 | Sign |
| flag_zf | output | 1 | Zero |
| flag_af | output | 1 | Carry out of bit 3 |
| flag_pf | output | 1 | Even parity of the low byte |
| valid | output | 1 | Result valid, one cycle after start |

## Verification
The bench builds the unit with its default 64-bit data width. At that width all four lanes exist, so the top-bit carry of each width and the two merge behaviours (keep upper bits, clear upper bits) can be reached. Directed vectors cover the wrap-around, signed overflow, zero and nibble-carry cases at each width, plus a 128-bit add done as two chained operations. Back-to-back starts exercise the `T_CHAIN` transition, and idle gaps confirm that the outputs hold between operations.

// File: rtl/adc_pkg.sv
package adc_pkg;
    localparam int NUM_SIZES = 4;
    localparam int SIZE_W    = 2;

    typedef enum logic [SIZE_W-1:0] {
        SZ_8  = 2'd0,
        SZ_16 = 2'd1,
        SZ_32 = 2'd2,
        SZ_64 = 2'd3
    } size_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } state_e;

    typedef struct packed {
        logic cf;
        logic of;
        logic sf;
        logic zf;
        logic af;
        logic pf;
    } flags_t;
endpackage

// File: rtl/adc_lane_adder.sv
module adc_lane_adder
    import adc_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic [DATA_W-1:0]                 op_a,
    input  logic [DATA_W-1:0]                 op_b,
    input  logic                              cin,
    output logic [NUM_SIZES-1:0][DATA_W-1:0]  lane_sum,
    output logic [NUM_SIZES-1:0]              lane_cout,
    output logic [NUM_SIZES-1:0]              lane_ovf
);
    // One adder per operand width; each lane has its own top-bit carry.
    for (genvar i = 0; i < NUM_SIZES; i++) begin : g_lane
        localparam int W = 8 << i;
        logic [W:0] raw;
        always_comb begin
            raw = {1'b0, op_a[W-1:0]} + {1'b0, op_b[W-1:0]} + {{W{1'b0}}, cin};
            lane_sum[i]  = DATA_W'(raw[W-1:0]);
            lane_cout[i] = raw[W];
            lane_ovf[i]  = (op_a[W-1] == op_b[W-1]) && (raw[W-1] != op_a[W-1]);
        end
    end
endmodule

// File: rtl/adc_flag_gen.sv
module adc_flag_gen
    import adc_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  size_e              sel,
    input  logic [DATA_W-1:0]  res,
    input  logic               a_bit4,
    input  logic               b_bit4,
    input  logic               cout,
    input  logic               ovf,
    output flags_t             flags
);
    logic msb;

    always_comb begin
        unique case (sel)
            SZ_8:    msb = res[7];
            SZ_16:   msb = res[15];
            SZ_32:   msb = res[31];
            default: msb = res[DATA_W-1];
        endcase
        flags.cf = cout;
        flags.of = ovf;
        flags.sf = msb;
        flags.zf = (res == '0);
        // Bit 4 of the sum is a4 ^ b4 ^ (carry into bit 4).
        flags.af = a_bit4 ^ b_bit4 ^ res[4];
        flags.pf = ~^res[7:0];
    end
endmodule

// File: rtl/adc_wb_merge.sv
module adc_wb_merge
    import adc_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  size_e              sel,
    input  logic [DATA_W-1:0]  old_val,
    input  logic [DATA_W-1:0]  res,
    output logic [DATA_W-1:0]  merged
);
    always_comb begin
        unique case (sel)
            SZ_8:    merged = {old_val[DATA_W-1:8],  res[7:0]};
            SZ_16:   merged = {old_val[DATA_W-1:16], res[15:0]};
            SZ_32:   merged = {{(DATA_W-32){1'b0}},  res[31:0]};
            default: merged = res;
        endcase
    end
endmodule

// File: rtl/adc_alu.sv
module adc_alu
    import adc_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [1:0]         size,
    input  logic [DATA_W-1:0]  dest_old,
    input  logic [DATA_W-1:0]  src,
    input  logic               carry_in,
    output logic [DATA_W-1:0]  wb_value,
    output logic               flag_cf,
    output logic               flag_of,
    output logic               flag_sf,
    output logic               flag_zf,
    output logic               flag_af,
    output logic               flag_pf,
    output logic               valid
);
    size_e                             sel;
    logic [NUM_SIZES-1:0][DATA_W-1:0]  lane_sum;
    logic [NUM_SIZES-1:0]              lane_cout;
    logic [NUM_SIZES-1:0]              lane_ovf;
    logic [DATA_W-1:0]                 res_sel;
    flags_t                            flags_d;
    flags_t                            flags_q;
    logic [DATA_W-1:0]                 merged_d;
    logic [DATA_W-1:0]                 wb_q;
    state_e                            state_q;
    state_e                            state_d;

    assign sel = size_e'(size);

    adc_lane_adder #(.DATA_W(DATA_W)) u_lanes (
        .op_a      (dest_old),
        .op_b      (src),
        .cin       (carry_in),
        .lane_sum  (lane_sum),
        .lane_cout (lane_cout),
        .lane_ovf  (lane_ovf)
    );

    assign res_sel = lane_sum[sel];

    adc_flag_gen #(.DATA_W(DATA_W)) u_flags (
        .sel    (sel),
        .res    (res_sel),
        .a_bit4 (dest_old[4]),
        .b_bit4 (src[4]),
        .cout   (lane_cout[sel]),
        .ovf    (lane_ovf[sel]),
        .flags  (flags_d)
    );

    adc_wb_merge #(.DATA_W(DATA_W)) u_merge (
        .sel     (sel),
        .old_val (dest_old),
        .res     (res_sel),
        .merged  (merged_d)
    );

    // Next-state logic: T_LAUNCH / T_CHAIN on start, T_RETIRE otherwise.
    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = start ? ST_EMIT : ST_IDLE;
            ST_EMIT: state_d = start ? ST_EMIT : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Output registers: loaded only when an operation is launched.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wb_q    <= '0;
            flags_q <= '0;
        end else if (start) begin
            wb_q    <= merged_d;
            flags_q <= flags_d;
        end
    end

    assign valid    = (state_q == ST_EMIT);
    assign wb_value = wb_q;
    assign flag_cf  = flags_q.cf;
    assign flag_of  = flags_q.of;
    assign flag_sf  = flags_q.sf;
    assign flag_zf  = flags_q.zf;
    assign flag_af  = flags_q.af;
    assign flag_pf  = flags_q.pf;

    p_valid_follows_start_r11: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> valid);
    p_no_spurious_valid_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> !valid);
    p_hold_when_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> $stable(wb_value) && $stable(flag_cf) && $stable(flag_zf));
    p_clear_upper_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (start && size == 2'd2) |=> wb_value[DATA_W-1:32] == '0);
    p_keep_upper_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (start && size == 2'd0) |=> wb_value[DATA_W-1:8] == $past(dest_old[DATA_W-1:8]));
    p_sign_byte_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (start && size == 2'd0) |=> flag_sf == wb_value[7]);
    p_zero_byte_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (start && size == 2'd0) |=> flag_zf == (wb_value[7:0] == 8'h00));
    p_parity_r7: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> flag_pf == ~^wb_value[7:0]);
endmodule

// File: tb/adc_alu_bench.sv
module adc_alu_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  size = 2'd0;
    logic [63:0] dest_old = '0;
    logic [63:0] src = '0;
    logic        carry_in = 1'b0;
    logic [63:0] wb_value;
    logic        flag_cf, flag_of, flag_sf, flag_zf, flag_af, flag_pf, valid;

    int n_vec = 0;
    int n_bad = 0;

    // Reference state, updated behaviourally once per clock.
    logic [63:0] e_wb = '0;
    logic        e_cf = 0, e_of = 0, e_sf = 0, e_zf = 0, e_af = 0, e_pf = 0, e_valid = 0;

    always #2.5 clk = ~clk;

    adc_alu u_adc_alu (
        .clk(clk), .rst_n(rst_n), .start(start), .size(size),
        .dest_old(dest_old), .src(src), .carry_in(carry_in),
        .wb_value(wb_value), .flag_cf(flag_cf), .flag_of(flag_of),
        .flag_sf(flag_sf), .flag_zf(flag_zf), .flag_af(flag_af),
        .flag_pf(flag_pf), .valid(valid)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic model(input logic [1:0] sz, input logic [63:0] d, input logic [63:0] s, input logic c);
        int w;
        logic [64:0] mask, sum;
        logic [63:0] r;
        logic da, sa, ra;
        w    = 8 << sz;
        mask = (65'd1 << w) - 65'd1;
        sum  = ({1'b0, d} & mask) + ({1'b0, s} & mask) + 65'(c);
        r    = 64'(sum & mask);
        e_cf = sum[w];
        da   = d[w-1];
        sa   = s[w-1];
        ra   = r[w-1];
        e_of = (da == sa) && (ra != da);
        e_sf = ra;
        e_zf = (r == 64'd0);
        e_af = (({1'b0, d[3:0]} + {1'b0, s[3:0]} + 5'(c)) >> 4) != 0;
        e_pf = ~^r[7:0];
        if (sz < 2) e_wb = (d & ~64'(mask)) | r;
        else        e_wb = r;
    endtask

    task automatic compare_all();
        chk("R11 valid", 64'(valid), 64'(e_valid));
        chk("R1/R8/R9/R10 wb_value", wb_value, e_wb);
        chk("R2 carry", 64'(flag_cf), 64'(e_cf));
        chk("R3 overflow", 64'(flag_of), 64'(e_of));
        chk("R4 sign", 64'(flag_sf), 64'(e_sf));
        chk("R5 zero", 64'(flag_zf), 64'(e_zf));
        chk("R6 nibble carry", 64'(flag_af), 64'(e_af));
        chk("R7 parity", 64'(flag_pf), 64'(e_pf));
    endtask

    // One clock: drive at negedge, update the model, compare at the next negedge.
    task automatic step(input logic st, input logic [1:0] sz, input logic [63:0] d, input logic [63:0] s, input logic c);
        start = st; size = sz; dest_old = d; src = s; carry_in = c;
        if (st) model(sz, d, s, c);
        e_valid = st;
        @(negedge clk);
        compare_all();
    endtask

    initial begin
        #1000000;
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        logic [63:0] lo_sum;
        repeat (3) @(negedge clk);
        compare_all(); // R12 reset state
        rst_n = 1'b1;
        @(negedge clk);
        compare_all();

        step(1, 2'd0, 64'h0A, 64'h05, 0);              // R1 no carry
        step(1, 2'd0, 64'h0A, 64'h05, 1);              // R1 carry in
        step(1, 2'd0, 64'h02, 64'hFF, 1);              // R2 wrap with carry out
        step(1, 2'd0, 64'h7F, 64'h01, 1);              // R3 overflow, R4 sign
        step(1, 2'd0, 64'h00, 64'hFF, 1);              // R5 zero with carry
        step(1, 2'd0, 64'h08, 64'h0A, 0);              // R6 nibble carry
        step(1, 2'd0, 64'h07, 64'h08, 1);              // R6 carry-in drives nibble carry
        step(1, 2'd0, 64'h01, 64'h02, 0);              // R7 parity
        step(0, 2'd3, 64'h1234, 64'h5678, 1);          // R11 idle, outputs hold
        step(0, 2'd0, 64'hFF, 64'hFF, 1);              // R11 idle
        step(1, 2'd0, 64'hDEADBEEF12345678, 64'h05, 0);    // R8 byte merge
        step(1, 2'd1, 64'hDEADBEEF12345678, 64'h1000, 0);  // R8 word merge
        step(1, 2'd1, 64'h0002, 64'hFFFF, 1);          // R2 16-bit wrap
        step(1, 2'd1, 64'h8000, 64'h7FFF, 1);          // R5 16-bit zero
        step(1, 2'd2, 64'hDEADBEEF12345678, 64'h10000000, 0); // R9 clear upper
        step(1, 2'd2, 64'h80000000, 64'h7FFFFFFF, 1);  // R9 wrap to zero
        step(1, 2'd3, 64'hFFFFFFFFFFFFFFFF, 64'hFFFFFFFFFFFFFFFF, 1); // R10 all ones
        step(1, 2'd3, 64'h1000000000000000, 64'hFFFFFFFFFFFFFFFF, 0); // R10 minus one
        step(1, 2'd3, 64'h8000000000000000, 64'h7FFFFFFFFFFFFFFF, 1); // R10 zero carry
        step(0, 2'd0, 64'h0, 64'h0, 0);

        // R2 chained 128-bit addition: low half, then high half using the carry.
        step(1, 2'd3, 64'hFFFFFFFFFFFFFFFF, 64'h2, 0);
        lo_sum = wb_value;
        step(1, 2'd3, 64'h1, 64'h0, flag_cf);
        chk("R2 chained low", lo_sum, 64'h1);
        chk("R2 chained high", wb_value, 64'h2);

        for (int i = 0; i < 400; i++) begin
            logic [63:0] d, s;
            d = {$urandom(), $urandom()};
            s = {$urandom(), $urandom()};
            if (i % 7 == 0) s = ~d;
            step(($urandom() % 4) != 0, 2'($urandom()), d, s, 1'($urandom()));
        end
        step(0, 2'd0, 64'h0, 64'h0, 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule